// File: doc/BRIEF.md
# Bounded-Error Approximation Monitor

This block watches two implementations of the same datapath while they run side by side. One is the exact design and the other is an approximate version. The monitor owns the startup of both. After its own reset it holds their reset line for a set number of cycles. It then gives them a one-cycle start pulse and then a steady enable. From that point on it compares their results.

Comparison is not bit-exact. Each result pair goes to a set of quality checkers. One checker bounds the worst-case absolute difference, with the bound given as a fraction of full scale. Another bounds how many bit positions differ. The checker verdicts are ORed into a single error flag. Once that flag is set it stays set until the next reset.

For sequential designs with unequal latencies, a small capture stage holds whichever result arrives first until its partner arrives. For purely combinational designs the capture stage is left out by a parameter, and the two buses are compared on every cycle of the run phase.

The startup controller has three states:
- SEQ_HOLD drives the reset of both designs.
- SEQ_KICK issues the start pulse.
- SEQ_RUN holds enable and arms checking.

It has three transitions:
- hold_done (SEQ_HOLD to SEQ_KICK) fires when the hold counter reaches its limit.
- kick_done (SEQ_KICK to SEQ_RUN) fires unconditionally after one cycle.
- run_stay (SEQ_RUN to SEQ_RUN) keeps the controller in the run state until reset.

Top module: `approx_err_monitor`

## Requirements
- R1: While `rst_n` is low, and for exactly `RST_CYCLES` clock cycles after it rises, `dut_rst` is 1 and `dut_start` and `dut_en` are 0. At most one of the three outputs is high in any cycle.
- R2: After the reset phase, `dut_start` is 1 for exactly one cycle with `dut_rst` and `dut_en` at 0. From the next cycle on, `dut_en` is 1 until `rst_n` falls.
- R3: Results presented while `dut_en` is 0 are discarded and never set `err_flag`, including a grossly mismatched pair.
- R4: The absolute-error checker flags a pair when |exact − approx| >= T, where T = floor((2^W − 1) × `BOUND_BP` / 10000). `BOUND_BP` is in units of 0.01 % of full scale. The difference is formed W+1 bits wide.
- R5: The bit-flip checker flags a pair when the number of differing bit positions in exact XOR approx is greater than `FLIP_LIMIT`.
- R6: `err_flag` is set if any enabled checker flags a pair. A checker turned off by `ABS_ON`=0 or `FLIP_ON`=0 contributes nothing.
- R7: In capture mode (`COMB_MODE`=0), a result marked by its valid strobe is held until the other design's result arrives. A lone result never sets `err_flag`. Each side may have at most one result waiting.
- R8: `err_flag` rises at the clock edge where a violating pair completes, and it stays 1 until `rst_n` falls, whatever later pairs show.
- R9: In combinational mode (`COMB_MODE`=1), the valid strobes are ignored and the two buses are checked on every cycle in which `dut_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the monitor |
| ex_valid | input | 1 | Exact design result strobe |
| ex_data | input | W | Exact design result |
| ap_valid | input | 1 | Approximate design result strobe |
| ap_data | input | W | Approximate design result |
| dut_rst | output | 1 | Reset driven to both designs |
| dut_start | output | 1 | One-cycle start pulse to both designs |
| dut_en | output | 1 | Run enable to both designs; checking armed |
| err_flag | output | 1 | Sticky quality-violation flag |

## Verification
The bench builds two instances, both with W=8, RST_CYCLES=3, BOUND_BP=200 (so T=5) and FLIP_LIMIT=3.

The first instance runs in capture mode with both checkers on. It is swept over a dense grid of 8-bit result pairs, with three arrival orders: simultaneous, exact first and approximate first. This puts both threshold edges, every pair alignment and the sticky behaviour within reach.

The second instance runs in combinational mode with the bit-flip checker off. It confirms that the valid strobes are ignored and that a flip-only violation is masked.

// File: rtl/amon_pkg.sv
package amon_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_KICK = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_t;

    localparam int NUM_CHK = 2;
    localparam int CHK_ABS  = 0;
    localparam int CHK_FLIP = 1;

endpackage

// File: rtl/amon_sequencer.sv
module amon_sequencer
    import amon_pkg::*;
#(
    parameter int RST_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic dut_rst,
    output logic dut_start,
    output logic dut_en
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    seq_state_t state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_HOLD: if (cnt == CW'(RST_CYCLES - 1)) nxt = SEQ_KICK;
            SEQ_KICK: nxt = SEQ_RUN;
            SEQ_RUN:  nxt = SEQ_RUN;
            default:  nxt = SEQ_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_HOLD;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (state == SEQ_HOLD) cnt <= cnt + CW'(1);
    end

    always_comb begin
        dut_rst   = 1'b0;
        dut_start = 1'b0;
        dut_en    = 1'b0;
        unique case (state)
            SEQ_HOLD: dut_rst   = 1'b1;
            SEQ_KICK: dut_start = 1'b1;
            SEQ_RUN:  dut_en    = 1'b1;
            default:  dut_rst   = 1'b1;
        endcase
    end

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dut_rst, dut_start, dut_en}));
    a_r2_start_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dut_start |-> $past(dut_rst));
    a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        dut_start |=> (!dut_start && dut_en));
    a_r2_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
        dut_en |=> dut_en);

endmodule

// File: rtl/amon_align.sv
module amon_align #(
    parameter int W         = 8,
    parameter bit COMB_MODE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         armed,
    input  logic         ex_valid,
    input  logic [W-1:0] ex_data,
    input  logic         ap_valid,
    input  logic [W-1:0] ap_data,
    output logic         fire,
    output logic [W-1:0] ex_cur,
    output logic [W-1:0] ap_cur
);
    generate
        if (COMB_MODE) begin : g_bypass
            always_comb begin
                fire   = armed;
                ex_cur = ex_data;
                ap_cur = ap_data;
            end
        end else begin : g_capture
            logic         ex_full, ap_full;
            logic [W-1:0] ex_hold, ap_hold;
            logic         ex_have, ap_have;

            always_comb begin
                ex_have = ex_full | ex_valid;
                ap_have = ap_full | ap_valid;
                ex_cur  = ex_full ? ex_hold : ex_data;
                ap_cur  = ap_full ? ap_hold : ap_data;
                fire    = armed & ex_have & ap_have;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ex_full <= 1'b0;
                    ap_full <= 1'b0;
                    ex_hold <= '0;
                    ap_hold <= '0;
                end else if (!armed || fire) begin
                    ex_full <= 1'b0;
                    ap_full <= 1'b0;
                end else begin
                    if (ex_valid) begin
                        ex_full <= 1'b1;
                        ex_hold <= ex_data;
                    end
                    if (ap_valid) begin
                        ap_full <= 1'b1;
                        ap_hold <= ap_data;
                    end
                end
            end

            a_r7_one_waiting_ex: assert property (@(posedge clk) disable iff (!rst_n)
                ex_full |-> !ex_valid);
            a_r7_one_waiting_ap: assert property (@(posedge clk) disable iff (!rst_n)
                ap_full |-> !ap_valid);
            a_r3_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
                !armed |=> (!ex_full && !ap_full));
        end
    endgenerate

endmodule

// File: rtl/amon_abs_chk.sv
module amon_abs_chk #(
    parameter int W     = 8,
    parameter int LIMIT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         viol
);
    localparam logic [W:0] LIM = (W + 1)'(LIMIT);

    logic [W:0] diff, mag;

    always_comb begin
        diff = {1'b0, x} - {1'b0, y};
        mag  = diff[W] ? (~diff + 1'b1) : diff;
        viol = (mag >= LIM);
    end

    a_r4_needs_difference: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (x != y));

endmodule

// File: rtl/amon_flip_chk.sv
module amon_flip_chk #(
    parameter int W     = 8,
    parameter int LIMIT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         viol
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) ones = ones + CW'(x[i] ^ y[i]);
        viol = (ones > CW'(LIMIT));
    end

    a_r5_needs_difference: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (x != y));

endmodule

// File: rtl/approx_err_monitor.sv
module approx_err_monitor
    import amon_pkg::*;
#(
    parameter int W          = 8,
    parameter int RST_CYCLES = 3,
    parameter int BOUND_BP   = 200,
    parameter int FLIP_LIMIT = 3,
    parameter bit ABS_ON     = 1'b1,
    parameter bit FLIP_ON    = 1'b1,
    parameter bit COMB_MODE  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ex_valid,
    input  logic [W-1:0] ex_data,
    input  logic         ap_valid,
    input  logic [W-1:0] ap_data,
    output logic         dut_rst,
    output logic         dut_start,
    output logic         dut_en,
    output logic         err_flag
);
    localparam int ABS_T = ((2 ** W - 1) * BOUND_BP) / 10000;

    logic               fire;
    logic [W-1:0]       ex_cur, ap_cur;
    logic [NUM_CHK-1:0] viol;

    amon_sequencer #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .dut_rst(dut_rst), .dut_start(dut_start), .dut_en(dut_en)
    );

    amon_align #(.W(W), .COMB_MODE(COMB_MODE)) u_align (
        .clk(clk), .rst_n(rst_n), .armed(dut_en),
        .ex_valid(ex_valid), .ex_data(ex_data),
        .ap_valid(ap_valid), .ap_data(ap_data),
        .fire(fire), .ex_cur(ex_cur), .ap_cur(ap_cur)
    );

    generate
        if (ABS_ON) begin : g_abs
            amon_abs_chk #(.W(W), .LIMIT(ABS_T)) u_abs (
                .clk(clk), .rst_n(rst_n), .x(ex_cur), .y(ap_cur), .viol(viol[CHK_ABS])
            );
        end else begin : g_no_abs
            assign viol[CHK_ABS] = 1'b0;
        end
        if (FLIP_ON) begin : g_flip
            amon_flip_chk #(.W(W), .LIMIT(FLIP_LIMIT)) u_flip (
                .clk(clk), .rst_n(rst_n), .x(ex_cur), .y(ap_cur), .viol(viol[CHK_FLIP])
            );
        end else begin : g_no_flip
            assign viol[CHK_FLIP] = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               err_flag <= 1'b0;
        else if (fire && |viol)   err_flag <= 1'b1;
    end

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    a_r3_rise_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(dut_en));

endmodule

// File: tb/approx_err_monitor_tb.sv
`timescale 1ns/1ps
module approx_err_monitor_tb;
    localparam int W = 8;
    localparam int RSTC = 3;
    localparam int TLIM = 5;
    localparam int FLIM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0, rst_c_n = 1'b0;
    logic ex_valid = 1'b0, ap_valid = 1'b0;
    logic [W-1:0] ex_data = '0, ap_data = '0;
    logic dut_rst, dut_start, dut_en, err_flag;
    logic c_rst, c_start, c_en, c_err;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    approx_err_monitor #(.W(W), .RST_CYCLES(RSTC), .BOUND_BP(200), .FLIP_LIMIT(FLIM),
        .ABS_ON(1'b1), .FLIP_ON(1'b1), .COMB_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_data(ex_data),
        .ap_valid(ap_valid), .ap_data(ap_data), .dut_rst(dut_rst),
        .dut_start(dut_start), .dut_en(dut_en), .err_flag(err_flag));

    approx_err_monitor #(.W(W), .RST_CYCLES(RSTC), .BOUND_BP(200), .FLIP_LIMIT(FLIM),
        .ABS_ON(1'b1), .FLIP_ON(1'b0), .COMB_MODE(1'b1)) u_dut_comb (
        .clk(clk), .rst_n(rst_c_n), .ex_valid(ex_valid), .ex_data(ex_data),
        .ap_valid(ap_valid), .ap_data(ap_data), .dut_rst(c_rst),
        .dut_start(c_start), .dut_en(c_en), .err_flag(c_err));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    function automatic int exp_abs(input int e, input int a);
        int d = (e > a) ? e - a : a - e;
        return (d >= TLIM) ? 1 : 0;
    endfunction

    function automatic int exp_flip(input int e, input int a);
        logic [W-1:0] x = W'(e) ^ W'(a);
        return ($countones(x) > FLIM) ? 1 : 0;
    endfunction

    task automatic reset_and_run();
        tick(); rst_n = 1'b0;
        tick(); rst_n = 1'b1;
        while (!dut_en) tick();
    endtask

    task automatic run_pair(input int e, input int a, input int skew, input bit sticky);
        int expv = (exp_abs(e, a) | exp_flip(e, a));
        reset_and_run();
        if (skew == 0) begin
            ex_valid = 1'b1; ex_data = W'(e); ap_valid = 1'b1; ap_data = W'(a);
            tick(); ex_valid = 1'b0; ap_valid = 1'b0;
        end else if (skew == 1) begin
            ex_valid = 1'b1; ex_data = W'(e);
            tick(); ex_valid = 1'b0; ex_data = '0;
            chk("R7 lone exact result", int'(err_flag), 0);
            tick();
            ap_valid = 1'b1; ap_data = W'(a);
            tick(); ap_valid = 1'b0;
        end else begin
            ap_valid = 1'b1; ap_data = W'(a);
            tick(); ap_valid = 1'b0; ap_data = '0;
            chk("R7 lone approx result", int'(err_flag), 0);
            ex_valid = 1'b1; ex_data = W'(e);
            tick(); ex_valid = 1'b0;
        end
        chk("R4/R5/R6 pair verdict", int'(err_flag), expv);
        if (sticky) begin
            ex_valid = 1'b1; ap_valid = 1'b1; ex_data = 8'h11; ap_data = 8'h11;
            tick(); ex_valid = 1'b0; ap_valid = 1'b0;
            tick();
            chk("R8 sticky after clean pair", int'(err_flag), expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: state during reset
        tick(); tick();
        chk("R1 reset dut_rst", int'(dut_rst), 1);
        chk("R1 reset dut_start", int'(dut_start), 0);
        chk("R1 reset dut_en", int'(dut_en), 0);
        chk("R8 reset err_flag", int'(err_flag), 0);
        // R1/R2: startup sequence length
        rst_n = 1'b1;
        n = 0;
        #1;
        while (dut_rst && n < 20) begin n++; tick(); end
        chk("R1 reset phase cycles", n, RSTC);
        chk("R2 start pulse", int'(dut_start), 1);
        chk("R2 no enable in pulse", int'(dut_en), 0);
        tick();
        chk("R2 start one cycle", int'(dut_start), 0);
        chk("R2 enable after start", int'(dut_en), 1);
        chk("R2 reset low in run", int'(dut_rst), 0);
        repeat (5) tick();
        chk("R2 enable held", int'(dut_en), 1);

        // R3: mismatched results before run are discarded
        tick(); rst_n = 1'b0;
        tick(); rst_n = 1'b1;
        ex_valid = 1'b1; ap_valid = 1'b1; ex_data = 8'h00; ap_data = 8'hFF;
        while (!dut_en) tick();
        ex_valid = 1'b0; ap_valid = 1'b0;
        chk("R3 no error before run", int'(err_flag), 0);
        ex_data = 8'h42; ap_data = 8'h42; ex_valid = 1'b1;
        tick(); ex_valid = 1'b0;
        ap_valid = 1'b1;
        tick(); ap_valid = 1'b0;
        chk("R3 discarded result left nothing pending", int'(err_flag), 0);

        // R4/R5 boundaries
        run_pair(100, 105, 0, 1'b0); // R4 diff == T
        run_pair(100, 104, 0, 1'b0); // R4 diff == T-1, 2 flips
        run_pair(3, 4, 1, 1'b0);     // R5 3 flips, diff 1
        run_pair(7, 8, 2, 1'b0);     // R5 4 flips, diff 1
        run_pair(128, 127, 0, 1'b1); // R6 flip-only, R8 sticky
        run_pair(255, 0, 1, 1'b1);   // R4 full-scale

        // Near-exhaustive grid with rotating arrival order (R4 R5 R6 R7 R8)
        n = 0;
        for (int e = 0; e < 256; e += 5) begin
            for (int a = 0; a < 256; a += 3) begin
                run_pair(e, a, n % 3, (n % 11) == 0);
                n++;
            end
        end

        // R9: combinational mode ignores strobes and compares every run cycle
        ex_valid = 1'b0; ap_valid = 1'b0;
        for (int e = 0; e < 256; e += 17) begin
            for (int a = 0; a < 256; a += 13) begin
                ex_data = '0; ap_data = '0;
                tick(); rst_c_n = 1'b0;
                tick(); rst_c_n = 1'b1;
                while (!c_en) tick();
                chk("R9 comb clean start", int'(c_err), 0);
                ex_data = W'(e); ap_data = W'(a);
                tick();
                ex_data = '0; ap_data = '0;
                chk("R9 comb verdict without strobes", int'(c_err), exp_abs(e, a));
            end
        end
        // R6: flip checker off in the comb instance masks a flip-only miss
        tick(); rst_c_n = 1'b0;
        tick(); rst_c_n = 1'b1;
        while (!c_en) tick();
        ex_data = 8'h80; ap_data = 8'h7F;
        tick();
        ex_data = '0; ap_data = '0;
        chk("R6 disabled flip checker silent", int'(c_err), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule